// File: doc/BRIEF.md
# Decode-Stage Data Hazard Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline and decides, each cycle, whether the instruction in decode may proceed. Decode reads the register file, but results are written back only in the last stage. A decode instruction can therefore need a value that an older instruction in execute, memory or writeback has not yet committed. The block compares the two decode source register numbers with the destination numbers of those three older stages. Each older stage also supplies a valid bit, a write-enable bit and, for the execute stage, a load flag.

When it detects a conflict, it raises three stall actions in the same cycle. The program counter holds its value, the fetch/decode register keeps its instruction, and the decode/execute register receives a nop instead of the decode instruction. A one-bit mode input selects the policy. In conservative mode there is no bypass network, so any pending write to a source register stalls. In bypass mode, every result except a load's is forwarded, so only a load in execute whose destination feeds the decode instruction stalls, for one cycle.

The block is purely combinational. All inputs come from existing pipeline registers.

Top module: `hz_stall_ctrl`

## Requirements
- R1: With `fwd_mode`=0, a valid decode instruction stalls when `id_ra` is nonzero and equals the destination of any valid, writing instruction in execute, memory or writeback.
- R2: With `fwd_mode`=0, the same rule applies to `id_rb`.
- R3: Register number 0 never causes a stall, whatever the older stages hold.
- R4: A stage whose valid bit or write-enable bit is 0 never causes a stall, even when its destination matches.
- R5: With `fwd_mode`=1, a stall occurs exactly when execute holds a valid, writing load (`ex_load`=1) with a nonzero destination equal to `id_ra` or `id_rb`.
- R6: With `fwd_mode`=1, non-load producers in any stage, and loads that have reached memory or writeback, cause no stall.
- R7: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal.
- R8: A decode slot with `id_valid`=0 never stalls.
- R9: In a pipeline, a consumer that directly follows its producer stalls for 3 cycles in mode 0, whether the producer is an add or a load. In mode 1 it stalls for 1 cycle after a load and 0 cycles after an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 0 = no bypass network, 1 = full bypass except load results |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_ra | input | REG_W | First source register of the decode instruction |
| id_rb | input | REG_W | Second source register of the decode instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a memory load |
| ex_rd | input | REG_W | Execute destination register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_W | Memory destination register |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | REG_W | Writeback destination register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a nop into the decode/execute register |

## Verification
Single-cycle vectors place one matching producer in each of execute, memory and writeback. Each is tried on the first source, then on the second, which separates the per-stage and per-source compare paths. The same matches are then repeated with register 0, with the valid bit cleared and with the write-enable bit cleared, and every one of those must stay quiet. Both modes are applied to each producer, so a load and an ALU result at the same distance show where the policies differ. Finally, a small pipeline model in the bench shifts an add or a load ahead of a dependent instruction and counts bubbles. That measures stall lengths of 3, 1 and 0 cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic {
        HZ_MODE_STALL_ALL = 1'b0,
        HZ_MODE_LOAD_ONLY = 1'b1
    } hz_mode_e;

    localparam int unsigned HZ_NSTG = 3;

    typedef enum int unsigned {
        HZ_STG_EX  = 0,
        HZ_STG_MEM = 1,
        HZ_STG_WB  = 2
    } hz_stg_e;

    typedef struct packed {
        logic valid;
        logic wen;
        logic load;
    } hz_wr_t;

    function automatic logic hz_writes(input hz_wr_t w);
        return w.valid & w.wen;
    endfunction

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSTG  = HZ_NSTG
) (
    input  logic                       src_used,
    input  logic [REG_W-1:0]           src,
    input  hz_wr_t [NSTG-1:0]          wr,
    input  logic [NSTG-1:0][REG_W-1:0] rd,
    output logic [NSTG-1:0]            hit
);
    logic src_live;
    assign src_live = src_used & (src != '0);

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        assign hit[s] = src_live & hz_writes(wr[s]) & (rd[s] == src);
    end
endmodule

// File: rtl/hz_policy.sv
module hz_policy
    import hz_pkg::*;
#(
    parameter int unsigned NSTG = HZ_NSTG
) (
    input  hz_mode_e         mode,
    input  logic [NSTG-1:0]  hit_a,
    input  logic [NSTG-1:0]  hit_b,
    input  hz_wr_t           ex_wr,
    output logic             stall
);
    logic [NSTG-1:0] hit_any;
    logic            stall_all;
    logic            stall_load;

    assign hit_any    = hit_a | hit_b;
    assign stall_all  = |hit_any;
    assign stall_load = hit_any[HZ_STG_EX] & ex_wr.load;

    always_comb begin
        unique case (mode)
            HZ_MODE_STALL_ALL: stall = stall_all;
            HZ_MODE_LOAD_ONLY: stall = stall_load;
            default:           stall = stall_all;
        endcase
    end
endmodule

// File: rtl/hz_fanout.sv
module hz_fanout (
    input  logic stall,
    output logic pc_hold,
    output logic ifid_hold,
    output logic idex_bubble
);
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             fwd_mode,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_ra,
    input  logic [REG_W-1:0] id_rb,
    input  logic             ex_valid,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_valid,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_valid,
    input  logic             wb_wen,
    input  logic [REG_W-1:0] wb_rd,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    localparam int unsigned NSTG = HZ_NSTG;

    hz_wr_t [NSTG-1:0]          wr;
    logic [NSTG-1:0][REG_W-1:0] rd;
    logic [NSTG-1:0]            hit_a;
    logic [NSTG-1:0]            hit_b;
    logic                       stall;
    hz_mode_e                   mode;

    assign mode = hz_mode_e'(fwd_mode);

    assign wr[HZ_STG_EX]  = '{valid: ex_valid,  wen: ex_wen,  load: ex_load};
    assign wr[HZ_STG_MEM] = '{valid: mem_valid, wen: mem_wen, load: 1'b0};
    assign wr[HZ_STG_WB]  = '{valid: wb_valid,  wen: wb_wen,  load: 1'b0};
    assign rd[HZ_STG_EX]  = ex_rd;
    assign rd[HZ_STG_MEM] = mem_rd;
    assign rd[HZ_STG_WB]  = wb_rd;

    hz_src_cmp #(.REG_W(REG_W), .NSTG(NSTG)) u_cmp_a (
        .src_used (id_valid),
        .src      (id_ra),
        .wr       (wr),
        .rd       (rd),
        .hit      (hit_a)
    );

    hz_src_cmp #(.REG_W(REG_W), .NSTG(NSTG)) u_cmp_b (
        .src_used (id_valid),
        .src      (id_rb),
        .wr       (wr),
        .rd       (rd),
        .hit      (hit_b)
    );

    hz_policy #(.NSTG(NSTG)) u_policy (
        .mode  (mode),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .ex_wr (wr[HZ_STG_EX]),
        .stall (stall)
    );

    hz_fanout u_fanout (
        .stall       (stall),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble)
    );
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic             fwd_mode,
    input logic             id_valid,
    input logic [REG_W-1:0] id_ra,
    input logic [REG_W-1:0] id_rb,
    input logic             ex_valid,
    input logic             ex_wen,
    input logic             ex_load,
    input logic [REG_W-1:0] ex_rd,
    input logic             mem_valid,
    input logic             mem_wen,
    input logic             wb_valid,
    input logic             wb_wen,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble
);
    always_comb begin
        p_all_three_r7: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        p_idle_slot_r8: assert (id_valid || !pc_hold);
        p_zero_src_r3: assert (id_ra != '0 || id_rb != '0 || !pc_hold);
        p_no_writer_r4: assert ((ex_valid && ex_wen) || (mem_valid && mem_wen)
                                || (wb_valid && wb_wen) || !pc_hold);
        p_load_only_r5: assert (!fwd_mode || !pc_hold
                                || (ex_valid && ex_wen && ex_load && ex_rd != '0));
    end
endmodule

bind hz_stall_ctrl hz_stall_chk #(.REG_W(REG_W)) u_chk (
    .fwd_mode    (fwd_mode),
    .id_valid    (id_valid),
    .id_ra       (id_ra),
    .id_rb       (id_rb),
    .ex_valid    (ex_valid),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .ex_rd       (ex_rd),
    .mem_valid   (mem_valid),
    .mem_wen     (mem_wen),
    .wb_valid    (wb_valid),
    .wb_wen      (wb_wen),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble)
);

// File: tb/hz_stall_ctrl_test.sv
module hz_stall_ctrl_test;
    localparam int W = 5;

    typedef struct packed {
        logic         valid;
        logic         wen;
        logic         load;
        logic [W-1:0] rd;
    } stg_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic fwd_mode;
    logic id_valid;
    logic [W-1:0] id_ra, id_rb;
    stg_t ex_s, mem_s, wb_s;
    logic pc_hold, ifid_hold, idex_bubble;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb[$];

    hz_stall_ctrl #(.REG_W(W)) uut (
        .fwd_mode    (fwd_mode),
        .id_valid    (id_valid),
        .id_ra       (id_ra),
        .id_rb       (id_rb),
        .ex_valid    (ex_s.valid),
        .ex_wen      (ex_s.wen),
        .ex_load     (ex_s.load),
        .ex_rd       (ex_s.rd),
        .mem_valid   (mem_s.valid),
        .mem_wen     (mem_s.wen),
        .mem_rd      (mem_s.rd),
        .wb_valid    (wb_s.valid),
        .wb_wen      (wb_s.wen),
        .wb_rd       (wb_s.rd),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble)
    );

    localparam stg_t EMPTY = '{valid: 1'b0, wen: 1'b0, load: 1'b0, rd: '0};

    function automatic stg_t mk(input logic v, input logic we, input logic ld, input int r);
        stg_t s;
        s.valid = v; s.wen = we; s.load = ld; s.rd = W'(r);
        return s;
    endfunction

    // monitor: compare all three actions at mid-cycle (R7 covered by every item)
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (pc_hold !== it.exp || ifid_hold !== it.exp || idex_bubble !== it.exp) begin
                bad++;
                $display("FAIL %s: pc=%b ifid=%b bubble=%b expected %b",
                         it.tag, pc_hold, ifid_hold, idex_bubble, it.exp);
            end
        end
    end

    task automatic vec(input logic m, input logic iv, input int ra, input int rb,
                       input stg_t e, input stg_t me, input stg_t w,
                       input logic exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        fwd_mode = m; id_valid = iv; id_ra = W'(ra); id_rb = W'(rb);
        ex_s = e; mem_s = me; wb_s = w;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // R9: shift a producer ahead of a dependent consumer and count bubbles
    task automatic pipe_run(input logic m, input logic prod_load, input int exp_cnt,
                            input string tag);
        int   cnt;
        logic st;
        logic done;
        @(posedge clk); #1;
        fwd_mode = m;
        ex_s = mk(1, 1, prod_load, 7); mem_s = EMPTY; wb_s = EMPTY;
        id_valid = 1'b1; id_ra = W'(7); id_rb = W'(2);
        cnt = 0; done = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (!done) begin
                @(negedge clk);
                st = pc_hold;
                @(posedge clk); #1;
                wb_s = mem_s; mem_s = ex_s;
                if (st) begin
                    cnt++;
                    ex_s = EMPTY;
                end else begin
                    ex_s = mk(1, 1, 0, 9);
                    id_ra = W'(3); id_rb = W'(4);
                    done = 1'b1;
                end
            end
        end
        total++;
        if (cnt != exp_cnt) begin
            bad++;
            $display("FAIL R9 %s: stalls=%0d expected %0d", tag, cnt, exp_cnt);
        end
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fwd_mode = 0; id_valid = 0; id_ra = '0; id_rb = '0;
        ex_s = EMPTY; mem_s = EMPTY; wb_s = EMPTY;

        vec(0, 0, 0, 0, EMPTY, EMPTY, EMPTY, 0, "R8 idle state");
        // R1 rA per stage
        vec(0, 1, 5, 1, mk(1,1,0,5), EMPTY, EMPTY, 1, "R1 rA vs EX");
        vec(0, 1, 5, 1, EMPTY, mk(1,1,0,5), EMPTY, 1, "R1 rA vs MEM");
        vec(0, 1, 5, 1, EMPTY, EMPTY, mk(1,1,0,5), 1, "R1 rA vs WB");
        vec(0, 1, 5, 1, mk(1,1,0,6), mk(1,1,0,8), mk(1,1,0,9), 0, "R1 no match");
        // R2 rB per stage
        vec(0, 1, 1, 12, mk(1,1,0,12), EMPTY, EMPTY, 1, "R2 rB vs EX");
        vec(0, 1, 1, 12, EMPTY, mk(1,1,0,12), EMPTY, 1, "R2 rB vs MEM");
        vec(0, 1, 1, 12, EMPTY, EMPTY, mk(1,1,0,12), 1, "R2 rB vs WB");
        // R3 register zero
        vec(0, 1, 0, 0, mk(1,1,0,0), mk(1,1,0,0), mk(1,1,0,0), 0, "R3 zero mode0");
        vec(1, 1, 0, 0, mk(1,1,1,0), EMPTY, EMPTY, 0, "R3 zero load mode1");
        // R4 invalid or non-writing
        vec(0, 1, 5, 5, mk(0,1,0,5), mk(0,1,0,5), mk(0,1,0,5), 0, "R4 invalid stages");
        vec(0, 1, 5, 5, mk(1,0,0,5), mk(1,0,0,5), mk(1,0,0,5), 0, "R4 no write enable");
        vec(1, 1, 5, 5, mk(0,1,1,5), EMPTY, EMPTY, 0, "R4 invalid load mode1");
        // R5 load-use in bypass mode
        vec(1, 1, 5, 1, mk(1,1,1,5), EMPTY, EMPTY, 1, "R5 load vs rA");
        vec(1, 1, 1, 5, mk(1,1,1,5), EMPTY, EMPTY, 1, "R5 load vs rB");
        vec(1, 1, 1, 2, mk(1,1,1,5), EMPTY, EMPTY, 0, "R5 load no match");
        // R6 no stall for ALU or older loads in bypass mode
        vec(1, 1, 5, 5, mk(1,1,0,5), mk(1,1,0,5), mk(1,1,0,5), 0, "R6 alu producers");
        vec(1, 1, 5, 5, EMPTY, mk(1,1,1,5), EMPTY, 0, "R6 load in MEM");
        // R8 idle slot with matches everywhere
        vec(0, 0, 5, 5, mk(1,1,1,5), mk(1,1,0,5), mk(1,1,0,5), 0, "R8 invalid decode");

        @(posedge clk); @(negedge clk);

        pipe_run(0, 0, 3, "add->sub mode0");
        pipe_run(1, 0, 0, "add->sub mode1");
        pipe_run(1, 1, 1, "load->use mode1");
        pipe_run(0, 1, 3, "load->use mode0");

        @(posedge clk); @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule